// File: doc/BRIEF.md
# Row-Hit-First DRAM Request Scheduler

This block sits in front of a multi-bank DRAM and decides which queued access goes out next. Read and write requests arrive on a valid/ready port. Each request carries a bank, a row, a column, a write flag and a tag. Accepted requests wait in a small queue. The scheduler also tracks, for every bank, whether a row is open and which row that is. It uses this state to sort the queue into row hits, requests to a closed bank, and requests that conflict with the open row.

Every cycle the scheduler looks at the requests whose bank is idle. A request that hits its bank's open row always wins over the others. Within the same class, the request that arrived first wins. The winner gets only the next command it needs. A conflict gets a precharge, a closed bank gets an activate, and a hit gets the column read or write. After that command, the bank stays busy for a fixed number of cycles.

A request leaves the queue only when its column command goes out. At that moment its tag is reported on the completion output. All banks share one command path, so at most one command is issued per cycle.

Top module: `rowhit_sched`

## Requirements
- R1: `req_ready` is low exactly when the queue already holds QDEPTH (default 8) requests. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high.
- R2: At most one command is issued per cycle. A command is never issued to a bank that is still busy with an earlier command.
- R3: Among the queued requests whose bank is idle, a request whose row equals its bank's open row is selected before any request that does not.
- R4: Among eligible requests of the same hit status, the one accepted earliest is selected.
- R5: A selected request whose bank has no open row produces an activate (`cmd_kind`=2) that carries its row. Its column command follows later.
- R6: A selected request whose bank holds a different open row produces a precharge (`cmd_kind`=1). An activate and then the column command follow later.
- R7: In the cycle a column command appears on the command output, `done_valid` is high and `done_tag` holds that request's tag. Every accepted request completes exactly once.
- R8: A column command is a read (`cmd_kind`=3) when the request's write flag is 0 and a write (`cmd_kind`=4) when it is 1. It carries the request's bank, row and column. The value 0 means no command.
- R9: After reset the queue is empty, `req_ready` is high, no command or completion is reported, and every bank has no open row.
- R10: A bank accepts its next command exactly T_COL (4) cycles after a column command, T_ACT (6) cycles after an activate and T_PRE (6) cycles after a precharge, if a request for it is waiting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Queue has a free slot |
| req_bank | input | BANKW (2) | Target bank |
| req_row | input | ROWW (8) | Target row |
| req_col | input | COLW (6) | Target column |
| req_we | input | 1 | 1 = write, 0 = read |
| req_tag | input | TAGW (4) | Request identifier |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_kind | output | 3 | 0 none, 1 precharge, 2 activate, 3 read, 4 write |
| cmd_bank | output | BANKW (2) | Bank of the command |
| cmd_row | output | ROWW (8) | Row of the request behind the command |
| cmd_col | output | COLW (6) | Column of the request behind the command |
| done_valid | output | 1 | A request completed this cycle |
| done_tag | output | TAGW (4) | Tag of the completed request |

## Verification
Assertions check these rules on every cycle:
- A bank is only given a command while it is idle, and it turns busy right after.
- An activate only goes to a closed bank, and a precharge only to an open one.
- A column command only goes to a bank whose open row matches the request.
- A queue entry is only removed while it is valid, and an accepted request grows the queue occupancy by one.
- A completion only appears together with a column command.

Some behaviour only the bench scenarios can show:
- that a younger row hit really overtakes an older conflict,
- that equal-class requests leave in arrival order,
- that the busy windows have the exact lengths,
- that every accepted tag completes once.

The bench shows these by comparing each cycle against an independent model of the policy, and with a short directed sequence whose command order and spacing are worked out by hand.

// File: rtl/rhs_pkg.sv
package rhs_pkg;
  // Command codes on the shared command path
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_PRE = 3'd1,
    CMD_ACT = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4
  } cmd_e;
endpackage

// File: rtl/rhs_queue.sv
// Request store with arrival rank: rank 0 is the oldest valid entry.
module rhs_queue #(
  parameter int DEPTH = 8,
  parameter int BANKW = 2,
  parameter int ROWW  = 8,
  parameter int COLW  = 6,
  parameter int TAGW  = 4,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        push,
  input  logic [BANKW-1:0]            push_bank,
  input  logic [ROWW-1:0]             push_row,
  input  logic [COLW-1:0]             push_col,
  input  logic                        push_we,
  input  logic [TAGW-1:0]             push_tag,
  input  logic                        pop,
  input  logic [IDXW-1:0]             pop_idx,
  output logic [DEPTH-1:0]            valid,
  output logic [DEPTH-1:0][BANKW-1:0] bank,
  output logic [DEPTH-1:0][ROWW-1:0]  row,
  output logic [DEPTH-1:0][COLW-1:0]  col,
  output logic [DEPTH-1:0]            we,
  output logic [DEPTH-1:0][TAGW-1:0]  tag,
  output logic [DEPTH-1:0][IDXW-1:0]  rank,
  output logic                        full
);
  logic [DEPTH-1:0]            valid_q;
  logic [DEPTH-1:0][IDXW-1:0]  rank_q;
  logic [DEPTH-1:0][BANKW-1:0] bank_q;
  logic [DEPTH-1:0][ROWW-1:0]  row_q;
  logic [DEPTH-1:0][COLW-1:0]  col_q;
  logic [DEPTH-1:0]            we_q;
  logic [DEPTH-1:0][TAGW-1:0]  tag_q;
  logic [IDXW:0]               count;
  logic [IDXW-1:0]             free_idx;
  logic [IDXW-1:0]             new_rank;

  always_comb begin
    count = '0;
    for (int i = 0; i < DEPTH; i++) count = count + (IDXW+1)'(valid_q[i]);
  end

  // lowest free slot
  always_comb begin
    free_idx = '0;
    for (int i = DEPTH-1; i >= 0; i--)
      if (!valid_q[i]) free_idx = IDXW'(i);
  end

  // a newcomer is younger than every entry that stays
  assign new_rank = count[IDXW-1:0] - IDXW'(pop);
  assign full     = (count == (IDXW+1)'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      rank_q  <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (pop && IDXW'(i) == pop_idx)
          valid_q[i] <= 1'b0;
        else if (pop && valid_q[i] && rank_q[i] > rank_q[pop_idx])
          rank_q[i] <= rank_q[i] - 1'b1;
      end
      if (push) begin
        valid_q[free_idx] <= 1'b1;
        rank_q[free_idx]  <= new_rank;
      end
    end
  end

  // payload fields: written only, no reset
  always_ff @(posedge clk) begin
    if (push) begin
      bank_q[free_idx] <= push_bank;
      row_q[free_idx]  <= push_row;
      col_q[free_idx]  <= push_col;
      we_q[free_idx]   <= push_we;
      tag_q[free_idx]  <= push_tag;
    end
  end

  assign valid = valid_q;
  assign rank  = rank_q;
  assign bank  = bank_q;
  assign row   = row_q;
  assign col   = col_q;
  assign we    = we_q;
  assign tag   = tag_q;

  // R7
  pop_live_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> valid_q[pop_idx]);

  // R1
  occupancy_grow_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |=> $countones(valid_q) == $past($countones(valid_q)) + 1);
endmodule

// File: rtl/rhs_bank.sv
// Per-bank open-row state and busy window.
module rhs_bank
  import rhs_pkg::*;
#(
  parameter int ROWW  = 8,
  parameter int CNTW  = 3,
  parameter int T_COL = 4,
  parameter int T_ACT = 6,
  parameter int T_PRE = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            issue,
  input  cmd_e            kind,
  input  logic [ROWW-1:0] row,
  output logic            idle,
  output logic            open,
  output logic [ROWW-1:0] open_row
);
  logic [CNTW-1:0] cnt_q;
  logic [CNTW-1:0] hold;
  logic            open_q;
  logic [ROWW-1:0] open_row_q;

  always_comb begin
    case (kind)
      CMD_PRE: hold = CNTW'(T_PRE - 1);
      CMD_ACT: hold = CNTW'(T_ACT - 1);
      default: hold = CNTW'(T_COL - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      open_q     <= 1'b0;
      open_row_q <= '0;
    end else if (issue) begin
      cnt_q <= hold;
      if (kind == CMD_PRE) open_q <= 1'b0;
      if (kind == CMD_ACT) begin
        open_q     <= 1'b1;
        open_row_q <= row;
      end
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign idle     = (cnt_q == '0);
  assign open     = open_q;
  assign open_row = open_row_q;

  // R2
  idle_issue_chk: assert property (@(posedge clk) disable iff (rst)
    issue |-> idle);

  // R10
  busy_after_chk: assert property (@(posedge clk) disable iff (rst)
    issue |=> !idle);

  // R5
  act_closed_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && kind == CMD_ACT) |-> !open_q);

  // R6
  pre_open_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && kind == CMD_PRE) |-> open_q);

  // R3
  col_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && (kind == CMD_RD || kind == CMD_WR)) |-> (open_q && open_row_q == row));
endmodule

// File: rtl/rhs_pick.sv
// Row-hit-first, then oldest, selection over idle-bank entries.
module rhs_pick
  import rhs_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int BANKS = 4,
  parameter int ROWW  = 8,
  localparam int BANKW = $clog2(BANKS),
  localparam int IDXW  = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]            valid,
  input  logic [DEPTH-1:0][BANKW-1:0] bank,
  input  logic [DEPTH-1:0][ROWW-1:0]  row,
  input  logic [DEPTH-1:0]            we,
  input  logic [DEPTH-1:0][IDXW-1:0]  rank,
  input  logic [BANKS-1:0]            bank_idle,
  input  logic [BANKS-1:0]            bank_open,
  input  logic [BANKS-1:0][ROWW-1:0]  bank_row,
  output logic                        found,
  output logic [IDXW-1:0]             idx,
  output cmd_e                        kind
);
  logic [DEPTH-1:0] elig;
  logic [DEPTH-1:0] hit;
  logic             best_hit;
  logic [IDXW-1:0]  best_rank;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      elig[i] = valid[i] && bank_idle[bank[i]];
      hit[i]  = bank_open[bank[i]] && (bank_row[bank[i]] == row[i]);
    end
  end

  always_comb begin
    found     = 1'b0;
    idx       = '0;
    best_hit  = 1'b0;
    best_rank = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (elig[i] && (!found || (hit[i] && !best_hit) ||
                      (hit[i] == best_hit && rank[i] < best_rank))) begin
        found     = 1'b1;
        idx       = IDXW'(i);
        best_hit  = hit[i];
        best_rank = rank[i];
      end
    end
  end

  always_comb begin
    if (!found)                 kind = CMD_NOP;
    else if (best_hit)          kind = we[idx] ? CMD_WR : CMD_RD;
    else if (bank_open[bank[idx]]) kind = CMD_PRE;
    else                        kind = CMD_ACT;
  end
endmodule

// File: rtl/rowhit_sched.sv
module rowhit_sched
  import rhs_pkg::*;
#(
  parameter int QDEPTH = 8,
  parameter int BANKS  = 4,
  parameter int ROWW   = 8,
  parameter int COLW   = 6,
  parameter int TAGW   = 4,
  parameter int T_COL  = 4,
  parameter int T_ACT  = 6,
  parameter int T_PRE  = 6,
  localparam int BANKW = $clog2(BANKS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [BANKW-1:0] req_bank,
  input  logic [ROWW-1:0]  req_row,
  input  logic [COLW-1:0]  req_col,
  input  logic             req_we,
  input  logic [TAGW-1:0]  req_tag,
  output logic             cmd_valid,
  output logic [2:0]       cmd_kind,
  output logic [BANKW-1:0] cmd_bank,
  output logic [ROWW-1:0]  cmd_row,
  output logic [COLW-1:0]  cmd_col,
  output logic             done_valid,
  output logic [TAGW-1:0]  done_tag
);
  localparam int IDXW = $clog2(QDEPTH);
  localparam int TMAX = (T_COL > T_ACT) ? ((T_COL > T_PRE) ? T_COL : T_PRE)
                                        : ((T_ACT > T_PRE) ? T_ACT : T_PRE);
  localparam int CNTW = $clog2(TMAX + 1);

  logic [QDEPTH-1:0]            q_valid;
  logic [QDEPTH-1:0][BANKW-1:0] q_bank;
  logic [QDEPTH-1:0][ROWW-1:0]  q_row;
  logic [QDEPTH-1:0][COLW-1:0]  q_col;
  logic [QDEPTH-1:0]            q_we;
  logic [QDEPTH-1:0][TAGW-1:0]  q_tag;
  logic [QDEPTH-1:0][IDXW-1:0]  q_rank;
  logic                         q_full;
  logic                         push;
  logic                         pop;

  logic [BANKS-1:0]             b_idle;
  logic [BANKS-1:0]             b_open;
  logic [BANKS-1:0][ROWW-1:0]   b_row;
  logic [BANKS-1:0]             b_issue;

  logic                         pk_found;
  logic [IDXW-1:0]              pk_idx;
  cmd_e                         pk_kind;

  logic                         cmd_valid_q;
  cmd_e                         cmd_kind_q;
  logic [BANKW-1:0]             cmd_bank_q;
  logic [ROWW-1:0]              cmd_row_q;
  logic [COLW-1:0]              cmd_col_q;
  logic                         done_valid_q;
  logic [TAGW-1:0]              done_tag_q;

  assign req_ready = !q_full;
  assign push      = req_valid && !q_full;
  assign pop       = pk_found && (pk_kind == CMD_RD || pk_kind == CMD_WR);

  rhs_queue #(
    .DEPTH(QDEPTH), .BANKW(BANKW), .ROWW(ROWW), .COLW(COLW), .TAGW(TAGW)
  ) queue_i (
    .clk(clk), .rst(rst),
    .push(push), .push_bank(req_bank), .push_row(req_row), .push_col(req_col),
    .push_we(req_we), .push_tag(req_tag),
    .pop(pop), .pop_idx(pk_idx),
    .valid(q_valid), .bank(q_bank), .row(q_row), .col(q_col), .we(q_we),
    .tag(q_tag), .rank(q_rank), .full(q_full)
  );

  rhs_pick #(
    .DEPTH(QDEPTH), .BANKS(BANKS), .ROWW(ROWW)
  ) pick_i (
    .valid(q_valid), .bank(q_bank), .row(q_row), .we(q_we), .rank(q_rank),
    .bank_idle(b_idle), .bank_open(b_open), .bank_row(b_row),
    .found(pk_found), .idx(pk_idx), .kind(pk_kind)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign b_issue[b] = pk_found && (q_bank[pk_idx] == BANKW'(b));
    rhs_bank #(
      .ROWW(ROWW), .CNTW(CNTW), .T_COL(T_COL), .T_ACT(T_ACT), .T_PRE(T_PRE)
    ) bank_i (
      .clk(clk), .rst(rst), .issue(b_issue[b]), .kind(pk_kind),
      .row(q_row[pk_idx]), .idle(b_idle[b]), .open(b_open[b]),
      .open_row(b_row[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid_q  <= 1'b0;
      cmd_kind_q   <= CMD_NOP;
      cmd_bank_q   <= '0;
      cmd_row_q    <= '0;
      cmd_col_q    <= '0;
      done_valid_q <= 1'b0;
      done_tag_q   <= '0;
    end else begin
      cmd_valid_q  <= pk_found;
      cmd_kind_q   <= pk_kind;
      cmd_bank_q   <= q_bank[pk_idx];
      cmd_row_q    <= q_row[pk_idx];
      cmd_col_q    <= q_col[pk_idx];
      done_valid_q <= pop;
      done_tag_q   <= q_tag[pk_idx];
    end
  end

  assign cmd_valid  = cmd_valid_q;
  assign cmd_kind   = cmd_kind_q;
  assign cmd_bank   = cmd_bank_q;
  assign cmd_row    = cmd_row_q;
  assign cmd_col    = cmd_col_q;
  assign done_valid = done_valid_q;
  assign done_tag   = done_tag_q;

  // R2
  one_bank_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(b_issue));

  // R7
  done_col_chk: assert property (@(posedge clk) disable iff (rst)
    done_valid_q |-> (cmd_valid_q && (cmd_kind_q == CMD_RD || cmd_kind_q == CMD_WR)));
endmodule

// File: tb/rowhit_sched_tb_top.sv
module rowhit_sched_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_bank = '0;
  logic [7:0] req_row = '0;
  logic [5:0] req_col = '0;
  logic       req_we = 1'b0;
  logic [3:0] req_tag = '0;
  logic       cmd_valid;
  logic [2:0] cmd_kind;
  logic [1:0] cmd_bank;
  logic [7:0] cmd_row;
  logic [5:0] cmd_col;
  logic       done_valid;
  logic [3:0] done_tag;

  always #2.5 clk = ~clk;

  rowhit_sched dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_we(req_we),
    .req_tag(req_tag), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
    .done_valid(done_valid), .done_tag(done_tag)
  );

  // {bank[2], row[8], col[6], we[1], tag[4]}
  localparam logic [20:0] VEC [0:15] = '{
    {2'd0, 8'd3, 6'd1, 1'b0, 4'd0}, {2'd0, 8'd9, 6'd2, 1'b1, 4'd1},
    {2'd0, 8'd3, 6'd3, 1'b0, 4'd2}, {2'd1, 8'd4, 6'd4, 1'b0, 4'd3},
    {2'd1, 8'd4, 6'd5, 1'b1, 4'd4}, {2'd2, 8'd7, 6'd6, 1'b0, 4'd5},
    {2'd0, 8'd9, 6'd7, 1'b0, 4'd6}, {2'd3, 8'd1, 6'd8, 1'b1, 4'd7},
    {2'd1, 8'd8, 6'd9, 1'b0, 4'd8}, {2'd0, 8'd3, 6'd10, 1'b1, 4'd9},
    {2'd2, 8'd7, 6'd11, 1'b0, 4'd10}, {2'd2, 8'd2, 6'd12, 1'b0, 4'd11},
    {2'd3, 8'd1, 6'd13, 1'b0, 4'd12}, {2'd1, 8'd4, 6'd14, 1'b0, 4'd13},
    {2'd0, 8'd9, 6'd15, 1'b1, 4'd14}, {2'd3, 8'd5, 6'd16, 1'b0, 4'd15}
  };

  int n_chk = 0, n_fail = 0;
  int m_v[8], m_b[8], m_r[8], m_c[8], m_w[8], m_t[8], m_s[8];
  int b_open[4], b_row[4], b_busy[4];
  int seq = 0, cyc = 0, n_acc = 0, n_done = 0;
  bit saw_full = 1'b0;
  bit logging = 1'b0;
  int n_log = 0;
  int log_kind[64], log_cyc[64], log_tag[64];

  function automatic int lat_of(int k);
    if (k == 1) return 6;
    if (k == 2) return 6;
    return 4;
  endfunction

  task automatic report_end();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic model_clear();
    for (int i = 0; i < 8; i++) m_v[i] = 0;
    for (int b = 0; b < 4; b++) begin b_open[b] = 0; b_row[b] = 0; b_busy[b] = 0; end
  endtask

  function automatic int model_count();
    int n = 0;
    for (int i = 0; i < 8; i++) n += m_v[i];
    return n;
  endfunction

  task automatic step(input bit pv, input int pb, input int pr, input int pc,
                      input int pw, input int pt, output bit acc);
    int pick, ek;
    bit best_hit, h, exp_ready;
    string tagr;
    @(negedge clk);
    req_valid = pv; req_bank = 2'(pb); req_row = 8'(pr);
    req_col = 6'(pc); req_we = pw[0]; req_tag = 4'(pt);
    exp_ready = (model_count() < 8);
    n_chk++;
    if (req_ready !== exp_ready) begin
      n_fail++;
      $display("FAIL R1 ready actual=%0b expected=%0b", req_ready, exp_ready);
    end
    pick = -1; best_hit = 0;
    for (int i = 0; i < 8; i++) begin
      if (m_v[i] != 0 && b_busy[m_b[i]] == 0) begin
        h = (b_open[m_b[i]] != 0) && (b_row[m_b[i]] == m_r[i]);
        if (pick < 0 || (h && !best_hit) || (h == best_hit && m_s[i] < m_s[pick])) begin
          pick = i; best_hit = h;
        end
      end
    end
    ek = 0;
    if (pick >= 0) ek = best_hit ? (m_w[pick] != 0 ? 4 : 3) : (b_open[m_b[pick]] != 0 ? 1 : 2);
    tagr = (ek == 1) ? "R6" : (ek == 2) ? "R5" : "R3/R4/R8";
    @(posedge clk); #1; cyc++;
    n_chk++;
    if (cmd_valid !== (pick >= 0) || (pick >= 0 && (cmd_kind !== 3'(ek) ||
        cmd_bank !== 2'(m_b[pick]) || cmd_row !== 8'(m_r[pick]) || cmd_col !== 6'(m_c[pick])))) begin
      n_fail++;
      $display("FAIL %s cmd actual=%0b/%0d b%0d r%0d c%0d expected=%0b/%0d b%0d r%0d c%0d",
               tagr, cmd_valid, cmd_kind, cmd_bank, cmd_row, cmd_col, pick >= 0, ek,
               pick >= 0 ? m_b[pick] : 0, pick >= 0 ? m_r[pick] : 0, pick >= 0 ? m_c[pick] : 0);
    end
    n_chk++;
    if (done_valid !== (ek >= 3) || (ek >= 3 && done_tag !== 4'(m_t[pick]))) begin
      n_fail++;
      $display("FAIL R7 done actual=%0b/%0d expected=%0b/%0d", done_valid, done_tag,
               ek >= 3, pick >= 0 ? m_t[pick] : 0);
    end
    if (logging && pick >= 0 && n_log < 64) begin
      log_kind[n_log] = ek; log_cyc[n_log] = cyc; log_tag[n_log] = m_t[pick]; n_log++;
    end
    for (int b = 0; b < 4; b++) if (b_busy[b] > 0) b_busy[b]--;
    if (pick >= 0) begin
      b_busy[m_b[pick]] = lat_of(ek) - 1;
      if (ek == 1) b_open[m_b[pick]] = 0;
      if (ek == 2) begin b_open[m_b[pick]] = 1; b_row[m_b[pick]] = m_r[pick]; end
      if (ek >= 3) begin m_v[pick] = 0; n_done++; end
    end
    if (!exp_ready) saw_full = 1'b1;
    acc = pv && exp_ready;
    if (acc) begin
      for (int i = 0; i < 8; i++) begin
        if (m_v[i] == 0) begin
          m_v[i] = 1; m_b[i] = pb; m_r[i] = pr; m_c[i] = pc; m_w[i] = pw; m_t[i] = pt;
          m_s[i] = seq; seq++; n_acc++;
          break;
        end
      end
    end
  endtask

  task automatic idle(input int n);
    bit a;
    for (int k = 0; k < n; k++) step(1'b0, 0, 0, 0, 0, 0, a);
  endtask

  task automatic drain();
    bit a;
    for (int k = 0; k < 3000 && model_count() > 0; k++) step(1'b0, 0, 0, 0, 0, 0, a);
    idle(8);
  endtask

  task automatic push_hold(input int pb, input int pr, input int pc, input int pw, input int pt);
    bit a = 1'b0;
    for (int k = 0; k < 3000 && !a; k++) step(1'b1, pb, pr, pc, pw, pt, a);
  endtask

  task automatic expect_int(input string r, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (R1..) actual=running expected=finished");
    report_end();
    $finish;
  end

  initial begin
    bit a;
    model_clear();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    expect_int("R9", "ready after reset", int'(req_ready), 1);
    expect_int("R9", "cmd_valid after reset", int'(cmd_valid), 0);
    expect_int("R9", "done_valid after reset", int'(done_valid), 0);

    // Directed: A(b0 r5 rd) B(b0 r7 wr) C(b0 r5 rd)
    logging = 1'b1; n_log = 0;
    step(1'b1, 0, 5, 1, 0, 1, a);
    step(1'b1, 0, 7, 2, 1, 2, a);
    step(1'b1, 0, 5, 3, 0, 3, a);
    drain();
    logging = 1'b0;
    expect_int("R9/R5", "commands in directed run", n_log, 6);
    expect_int("R5", "first cmd is activate", log_kind[0], 2);
    expect_int("R4", "older hit A first", log_tag[1], 1);
    expect_int("R3", "younger hit C before older conflict B", log_tag[2], 3);
    expect_int("R6", "conflict precharge", log_kind[3], 1);
    expect_int("R6", "activate after precharge", log_kind[4], 2);
    expect_int("R8", "write command for B", log_kind[5], 4);
    expect_int("R7", "B completes last", log_tag[5], 2);
    expect_int("R10", "activate to column gap", log_cyc[1] - log_cyc[0], 6);
    expect_int("R10", "column to column gap", log_cyc[2] - log_cyc[1], 4);
    expect_int("R2", "column to precharge gap", log_cyc[3] - log_cyc[2], 4);
    expect_int("R10", "precharge to activate gap", log_cyc[4] - log_cyc[3], 6);
    expect_int("R10", "activate to write gap", log_cyc[5] - log_cyc[4], 6);

    // Table walk, checked cycle by cycle against the model
    foreach (VEC[i]) begin
      push_hold(int'(VEC[i][20:19]), int'(VEC[i][18:11]), int'(VEC[i][10:5]),
                int'(VEC[i][4]), int'(VEC[i][3:0]));
    end
    drain();

    // Queue fill: conflicting rows on one bank
    for (int k = 0; k < 12; k++) push_hold(1, 20 + k, k, k % 2, k);
    drain();
    expect_int("R1", "queue reached full", int'(saw_full), 1);
    expect_int("R7", "every accepted request completed", n_done, n_acc);

    // Reset mid-traffic then re-check reset state
    step(1'b1, 2, 1, 1, 0, 1, a);
    @(negedge clk); req_valid = 1'b0; rst = 1'b1;
    @(posedge clk); #1;
    @(negedge clk); rst = 1'b0; model_clear();
    expect_int("R9", "ready after second reset", int'(req_ready), 1);
    expect_int("R9", "no command after second reset", int'(cmd_valid), 0);
    step(1'b1, 2, 1, 4, 0, 5, a);
    idle(2);
    drain();

    report_end();
    $finish;
  end
endmodule